// File: doc/BRIEF.md
# SDRAM Mode Word and Burst Timing Engine

This block models the device side of a single-bank synchronous DRAM: a command/data timing engine. A load-mode command stores a mode word. From that word the block takes the burst length, the read latency, the operating mode and a write-burst option. It then runs READ and WRITE bursts against a small internal storage array that is organised in rows and columns.

Read data leaves through a registered output word and an output-enable. The output-enable comes up one cycle before the first word, and each burst walks the column address inside an aligned block. The selected read latency appears on a port. The latency-2 setting is only permitted at lower clock rates than latency 3, so a controller can check the setting against its own clock rate. A mode word with any reserved field is refused and leaves a sticky flag.

Commands are sampled on each rising clock edge. The command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3 and LOAD MODE=4. The other codes act as NOP.

Top module: `sdram_burst_engine`

## Requirements
- R1: After reset, dq_oe_o is 0, dout_o is 0, cas_lat_o is 2, illegal_mode_o is 0. Bursts are one word long and writes follow the burst length.
- R2: A LOAD MODE command takes its mode word from addr_i bits 9:0. Bits 2:0 select the burst length: 000=1, 001=2, 010=4, 011=8. Bits 6:4 select the latency: 010=2, 011=3. Bits 8:7 must be 00 for normal mode. Bit 9 set makes writes single-location. A legal word applies to every later command, and cas_lat_o shows the new latency after the edge that registered the load.
- R3: For a READ registered at edge n with latency m, word k of the burst is on dout_o after edge n+m+k.
- R4: dq_oe_o rises after edge n+m-1, one cycle before the first word. It stays high through the last word and falls at the next edge. dout_o is 0 in every cycle that carries no read word.
- R5: Burst column addresses count up from the start column and wrap inside the block of burst-length columns aligned to that length. For example, with length 4 a start at column 6 gives columns 6, 7, 4, 5.
- R6: A WRITE registered at edge n stores the din_i value present at edge n+k into burst column k, for every word of the burst.
- R7: With mode bit 9 set, a WRITE stores only its first word at the start column. READs still use the full programmed burst length.
- R8: A LOAD MODE whose length code is above 011, whose latency code is not 010 or 011, or whose bits 8:7 are not 00 sets illegal_mode_o. The flag stays set until reset, and every earlier mode setting stays in force.
- R9: ACTIVE latches addr_i bits ROW_W-1:0 as the open row. READ and WRITE take their start column from addr_i bits COL_W-1:0 within that row.
- R10: A READ registered at the edge right after the previous burst's last issue cycle continues the stream: dq_oe_o stays high between the two bursts with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code (NOP, ACTIVE, READ, WRITE, LOAD MODE) |
| addr_i | input | ADDR_W | Row, column or mode word, depending on the command |
| din_i | input | DATA_W | Write data, one word per edge of a write burst |
| dout_o | output | DATA_W | Read data word, zero when no word is presented |
| dq_oe_o | output | 1 | Output drive enable for the read data path |
| cas_lat_o | output | 2 | Read latency now in force (2 or 3) |
| illegal_mode_o | output | 1 | Sticky flag for a refused mode word |

## Verification
Each result has a fixed due cycle relative to the command edge n. The latency port and the illegal flag change at edge n itself. The output-enable rises at edge n+m-1 and falls at edge n+m+BL. Word k of a read appears at edge n+m+k, and write word k is stored at edge n+k. A write can only be seen through a later read burst. The bench drives every input on the falling edge and samples on the following falling edge. For a read it walks t = 0 to m+BL after edge n and compares dq_oe_o and dout_o in every one of those cycles, so an early, late or missing word is caught as well as a wrong one. Back-to-back reads and refused mode words are checked over the same cycle-by-cycle window.

// File: rtl/sdr_pkg.sv
`timescale 1ns/1ps
package sdr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_LOAD = 3'd4
  } cmd_e;

  localparam int MODE_W = 10;

  typedef struct packed {
    logic [1:0] len_log;    // burst length = 1 << len_log
    logic       lat3;       // 1: latency 3, 0: latency 2
    logic       wr_single;  // writes touch one location only
  } mode_t;

  // true when every field of a mode word holds a supported code
  function automatic logic mode_word_ok(input logic [MODE_W-1:0] w);
    logic len_ok, lat_ok, op_ok;
    len_ok = (w[2] == 1'b0);
    lat_ok = (w[6:4] == 3'd2) || (w[6:4] == 3'd3);
    op_ok  = (w[8:7] == 2'b00);
    return len_ok && lat_ok && op_ok;
  endfunction
endpackage

// File: rtl/sdr_mode_reg.sv
`timescale 1ns/1ps
module sdr_mode_reg
  import sdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode_q,
  output logic              illegal_q
);
  logic word_ok;
  logic unused_mode_bits;

  assign word_ok          = mode_word_ok(word);
  assign unused_mode_bits = word[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '{len_log: 2'd0, lat3: 1'b0, wr_single: 1'b0};
      illegal_q <= 1'b0;
    end else if (load) begin
      if (word_ok) begin
        mode_q <= '{len_log: word[1:0], lat3: word[4], wr_single: word[9]};
      end else begin
        illegal_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdr_burst_seq.sv
`timescale 1ns/1ps
module sdr_burst_seq #(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       len_log,
  input  logic             wr_single,
  output logic             rd_issue,
  output logic [COL_W-1:0] rd_col,
  output logic             wr_en,
  output logic [COL_W-1:0] wr_col
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic             busy_q;
  logic             is_wr_q;
  logic [COL_W-1:0] col_q;
  logic [2:0]       left_q;
  logic [3:0]       span_m1;
  logic [COL_W-1:0] mask;
  logic             wr_more;

  // next column, wrapping inside the aligned block selected by m
  function automatic logic [COL_W-1:0] step(input logic [COL_W-1:0] c,
                                            input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + ONE) & m);
  endfunction

  always_comb begin
    span_m1 = (4'd1 << len_log) - 4'd1;
    mask    = COL_W'(span_m1);
    wr_more = !wr_single && (span_m1 != 4'd0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      is_wr_q <= 1'b0;
      col_q   <= '0;
      left_q  <= '0;
    end else if (start_rd) begin
      busy_q  <= 1'b1;
      is_wr_q <= 1'b0;
      col_q   <= start_col;
      left_q  <= span_m1[2:0];
    end else if (start_wr) begin
      // first write word is stored on the command edge itself
      busy_q  <= wr_more;
      is_wr_q <= 1'b1;
      col_q   <= step(start_col, mask);
      left_q  <= span_m1[2:0] - 3'd1;
    end else if (busy_q) begin
      if (left_q == 3'd0) begin
        busy_q <= 1'b0;
      end else begin
        col_q  <= step(col_q, mask);
        left_q <= left_q - 3'd1;
      end
    end
  end

  assign rd_issue = busy_q && !is_wr_q;
  assign rd_col   = col_q;
  assign wr_en    = start_wr || (busy_q && is_wr_q);
  assign wr_col   = start_wr ? start_col : col_q;
endmodule

// File: rtl/sdr_store.sv
`timescale 1ns/1ps
module sdr_store #(
  parameter int DATA_W = 16,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sdr_read_pipe.sv
`timescale 1ns/1ps
module sdr_read_pipe #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_v,
  input  logic [DATA_W-1:0] rdata,
  input  logic              lat3,
  output logic [DATA_W-1:0] dout_q,
  output logic              oe_q,
  output logic              dvalid_q
);
  logic              v0_q;   // aligned with rdata
  logic              v1_q;   // aligned with s1_q
  logic [DATA_W-1:0] s1_q;

  always_ff @(posedge clk) begin
    s1_q <= rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v0_q     <= 1'b0;
      v1_q     <= 1'b0;
      dvalid_q <= 1'b0;
      oe_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      v0_q <= issue_v;
      v1_q <= v0_q;
      if (lat3) begin
        dvalid_q <= v1_q;
        dout_q   <= v1_q ? s1_q : '0;
        oe_q     <= v0_q || v1_q;
      end else begin
        dvalid_q <= v0_q;
        dout_q   <= v0_q ? rdata : '0;
        oe_q     <= issue_v || v0_q;
      end
    end
  end
endmodule

// File: rtl/sdram_burst_engine.sv
`timescale 1ns/1ps
module sdram_burst_engine
  import sdr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dq_oe_o,
  output logic [1:0]        cas_lat_o,
  output logic              illegal_mode_o
);
  localparam int AW = ROW_W + COL_W;

  mode_t             mode_q;
  logic [ROW_W-1:0]  row_q;
  logic              rd_issue, wr_en;
  logic [COL_W-1:0]  rd_col, wr_col;
  logic [DATA_W-1:0] rdata;
  logic              data_vld;
  logic              unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-1:MODE_W];

  sdr_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .load      (cmd_i == CMD_LOAD),
    .word      (addr_i[MODE_W-1:0]),
    .mode_q    (mode_q),
    .illegal_q (illegal_mode_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                  row_q <= '0;
    else if (cmd_i == CMD_ACT) row_q <= addr_i[ROW_W-1:0];
  end

  sdr_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_rd  (cmd_i == CMD_RD),
    .start_wr  (cmd_i == CMD_WR),
    .start_col (addr_i[COL_W-1:0]),
    .len_log   (mode_q.len_log),
    .wr_single (mode_q.wr_single),
    .rd_issue  (rd_issue),
    .rd_col    (rd_col),
    .wr_en     (wr_en),
    .wr_col    (wr_col)
  );

  sdr_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr ({row_q, wr_col}),
    .wdata (din_i),
    .raddr ({row_q, rd_col}),
    .rdata (rdata)
  );

  sdr_read_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .issue_v  (rd_issue),
    .rdata    (rdata),
    .lat3     (mode_q.lat3),
    .dout_q   (dout_o),
    .oe_q     (dq_oe_o),
    .dvalid_q (data_vld)
  );

  assign cas_lat_o = mode_q.lat3 ? 2'd3 : 2'd2;
endmodule

// File: rtl/sdram_burst_engine_chk.sv
`timescale 1ns/1ps
module sdram_burst_engine_chk
  import sdr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmd_i,
  input logic [MODE_W-1:0] mode_word,
  input logic [DATA_W-1:0] dout_o,
  input logic              dq_oe_o,
  input logic [1:0]        cas_lat_o,
  input logic              illegal_mode_o,
  input logic              data_vld
);
  logic load_ok, load_bad;
  logic unused_word_bits;

  assign unused_word_bits = mode_word[3] ^ mode_word[9];
  assign load_ok  = (cmd_i == CMD_LOAD) && (mode_word[2] == 1'b0) &&
                    (mode_word[6:4] == 3'd2 || mode_word[6:4] == 3'd3) &&
                    (mode_word[8:7] == 2'b00);
  assign load_bad = (cmd_i == CMD_LOAD) && !load_ok;

  p_lat_range_r2: assert property (@(posedge clk) disable iff (rst)
    cas_lat_o == 2'd2 || cas_lat_o == 2'd3);

  p_lat_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> cas_lat_o == (($past(mode_word[6:4]) == 3'd3) ? 2'd3 : 2'd2));

  p_refuse_keep_r8: assert property (@(posedge clk) disable iff (rst)
    load_bad |=> $stable(cas_lat_o) && illegal_mode_o);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_mode_o |=> illegal_mode_o);

  p_oe_leads_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_vld) |-> $past(dq_oe_o));

  p_data_driven_r4: assert property (@(posedge clk) disable iff (rst)
    data_vld |-> dq_oe_o);

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !data_vld |-> dout_o == '0);

  p_oe_drop_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe_o) |-> $past(data_vld));
endmodule

bind sdram_burst_engine sdram_burst_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cmd_i          (cmd_i),
  .mode_word      (addr_i[sdr_pkg::MODE_W-1:0]),
  .dout_o         (dout_o),
  .dq_oe_o        (dq_oe_o),
  .cas_lat_o      (cas_lat_o),
  .illegal_mode_o (illegal_mode_o),
  .data_vld       (data_vld)
);

// File: tb/sdram_burst_engine_test.sv
`timescale 1ns/1ps
module sdram_burst_engine_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    cmd;
  logic [11:0]   addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          oe;
  logic [1:0]    cas;
  logic          illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cur_row = 0;
  logic [DW-1:0] model [64];

  always #2.5 clk = ~clk;

  sdram_burst_engine uut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .addr_i(addr), .din_i(din),
    .dout_o(dout), .dq_oe_o(oe), .cas_lat_o(cas), .illegal_mode_o(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mw(input logic [2:0] len, input logic [2:0] lat,
                                     input logic [1:0] op, input logic single);
    return {2'b00, single, op, lat, 1'b0, len};
  endfunction

  function automatic int wrap(input int col, input int k, input int bl);
    return (col & ~(bl - 1)) | ((col + k) & (bl - 1));
  endfunction

  task automatic load_mode(input logic [11:0] w);
    @(negedge clk); cmd = 3'd4; addr = w;
    @(negedge clk); cmd = 3'd0;
  endtask

  task automatic activate(input int row);
    @(negedge clk); cmd = 3'd1; addr = 12'(row);
    @(negedge clk); cmd = 3'd0;
    cur_row = row;
  endtask

  // drives nbeats data words; the model takes the first nstore of them
  task automatic write_burst(input int col, input int nbeats, input int nstore,
                             input int bl, input logic [DW-1:0] seed);
    for (int k = 0; k < nbeats; k++) begin
      @(negedge clk);
      cmd  = (k == 0) ? 3'd3 : 3'd0;
      addr = 12'(col);
      din  = seed + DW'(k * 16'h0111);
      if (k < nstore) model[cur_row * 16 + wrap(col, k, bl)] = din;
    end
    @(negedge clk); cmd = 3'd0;
  endtask

  task automatic read_burst(input string req, input int col, input int bl, input int m);
    logic [DW-1:0] exp_w [8];
    for (int k = 0; k < bl; k++) exp_w[k] = model[cur_row * 16 + wrap(col, k, bl)];
    @(negedge clk); cmd = 3'd2; addr = 12'(col);
    @(posedge clk);
    for (int t = 0; t <= m + bl; t++) begin
      @(negedge clk);
      cmd = 3'd0;
      chk(req, $sformatf("oe t=%0d", t), 32'(oe), 32'((t >= m - 1) && (t <= m + bl - 1)));
      chk(req, $sformatf("dout t=%0d", t), 32'(dout),
          32'((t >= m && t < m + bl) ? exp_w[t - m] : '0));
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; cmd = 3'd0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", "oe", 32'(oe), 32'd0);
    chk("R1", "dout", 32'(dout), 32'd0);
    chk("R1", "cas", 32'(cas), 32'd2);
    chk("R1", "illegal", 32'(illegal), 32'd0);
  endtask

  task automatic t_rows;
    activate(1);
    write_burst(5, 1, 1, 1, 16'hA5A5);
    activate(2);
    write_burst(5, 1, 1, 1, 16'h3C3C);
    read_burst("R1 R3 R4 R9 row2", 5, 1, 2);
    activate(1);
    read_burst("R9 row1", 5, 1, 2);
  endtask

  task automatic t_len4;
    load_mode(mw(3'd2, 3'd2, 2'd0, 1'b0));
    chk("R2", "cas after load", 32'(cas), 32'd2);
    write_burst(4, 4, 4, 4, 16'h1000);
    read_burst("R6 R3", 4, 4, 2);
    read_burst("R5 wrap", 6, 4, 2);
  endtask

  task automatic t_lat3;
    load_mode(mw(3'd3, 3'd3, 2'd0, 1'b0));
    chk("R2", "cas lat3", 32'(cas), 32'd3);
    write_burst(8, 8, 8, 8, 16'h2000);
    read_burst("R2 R3 R4 R5 lat3", 11, 8, 3);
  endtask

  task automatic t_back_to_back;
    logic [DW-1:0] w [4];
    load_mode(mw(3'd1, 3'd2, 2'd0, 1'b0));
    for (int k = 0; k < 4; k++) w[k] = model[cur_row * 16 + 4 + k];
    @(negedge clk); cmd = 3'd2; addr = 12'd4;
    @(posedge clk);
    for (int t = 0; t <= 6; t++) begin
      @(negedge clk);
      chk("R10", $sformatf("oe t=%0d", t), 32'(oe), 32'((t >= 1) && (t <= 5)));
      chk("R10", $sformatf("dout t=%0d", t), 32'(dout),
          32'((t >= 2 && t <= 5) ? w[t - 2] : '0));
      if (t == 1) begin cmd = 3'd2; addr = 12'd6; end
      else cmd = 3'd0;
    end
  endtask

  task automatic t_single_write;
    load_mode(mw(3'd2, 3'd2, 2'd0, 1'b1));
    write_burst(8, 4, 1, 4, 16'h7700);
    read_burst("R7", 8, 4, 2);
  endtask

  task automatic t_refused;
    chk("R8", "flag before", 32'(illegal), 32'd0);
    load_mode(mw(3'd3, 3'd3, 2'b01, 1'b0));
    chk("R8", "flag opmode", 32'(illegal), 32'd1);
    chk("R8", "cas kept", 32'(cas), 32'd2);
    load_mode(mw(3'd1, 3'd1, 2'd0, 1'b0));
    chk("R8", "cas kept lat code", 32'(cas), 32'd2);
    load_mode(mw(3'd4, 3'd3, 2'd0, 1'b0));
    chk("R8", "cas kept len code", 32'(cas), 32'd2);
    // length 4 and single-location writes must still hold
    write_burst(12, 4, 1, 4, 16'h5500);
    read_burst("R8 settings kept", 12, 4, 2);
    load_mode(mw(3'd0, 3'd2, 2'd0, 1'b0));
    chk("R8", "flag sticky", 32'(illegal), 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    t_rows();
    t_len4();
    t_lat3();
    t_back_to_back();
    t_single_write();
    t_refused();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule